// File: doc/BRIEF.md
# Paging Address Codeword Matcher

This block sits behind a batch framer in a paging receiver. It accepts one aligned 32-bit codeword per transfer, together with the index (0 to 7) of the frame slot the codeword arrived in. Each codeword is put into one of three classes: idle filler, address or message. An address codeword is then compared against a small programmable table of 21-bit receiver identities. A codeword holds only the upper 18 identity bits. The lower 3 bits are taken from the frame slot in which the codeword arrives.

For every accepted codeword the block gives one result cycle. That cycle carries the class, and for an address that matches, it also carries the index of the matching table entry and the two function bits that select the call type. Table entries are loaded through a plain write port. A table write has priority over the codeword stream. In any cycle that carries a write, `in_ready` is low and no codeword is taken. The framer must hold `in_word` and `in_frame` steady while `in_valid` is high and `in_ready` is low. A write is dropped if a codeword is still inside the block, so the table never changes under a codeword that is being compared.

Top module: `paging_addr_matcher`

## Requirements
- R1: After reset every table entry is disabled, so no codeword produces a hit, and `out_valid` and `hit` are low.
- R2: A word equal to 32'h7A89C197 is reported as class 0 (idle) and never hits, even when an enabled entry holds its bits.
- R3: A word with bit 31 set is reported as class 2 (message) and never hits.
- R4: Any other word is reported as class 1 (address). It hits when an enabled entry has identity bits [20:3] equal to word bits [30:13] and identity bits [2:0] equal to `in_frame`.
- R5: An address codeword whose upper 18 bits match an entry but which arrives in a different frame slot does not hit that entry.
- R6: On a hit, `hit_func` equals word bits {12,11}: bit 12 of the word drives `hit_func[1]` and bit 11 drives `hit_func[0]`.
- R7: When several enabled entries match, `hit_idx` is the lowest matching index.
- R8: An entry whose enable bit is cleared never hits.
- R9: A codeword accepted at clock edge k gives exactly one `out_valid` cycle, registered at edge k+1. Codewords sent back to back give results back to back, in order.
- R10: `in_ready` is low in every cycle where `wr_en` is high, and a codeword offered in such a cycle is not taken.
- R11: A table write presented while a codeword is held inside the block (the cycle right after that codeword is accepted) is dropped, and the table is left unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Codeword offered |
| in_ready | output | 1 | Codeword can be taken (low while a write is presented) |
| in_word | input | 32 | Aligned codeword; the first transmitted bit is bit 31 |
| in_frame | input | 3 | Frame slot index of the codeword |
| wr_en | input | 1 | Table write strobe |
| wr_idx | input | 2 | Table entry to write |
| wr_id | input | 21 | Identity to store |
| wr_on | input | 1 | Enable bit to store |
| out_valid | output | 1 | One-cycle result strobe |
| out_class | output | 2 | 0 idle, 1 address, 2 message |
| hit | output | 1 | Address matched an enabled entry |
| hit_idx | output | 2 | Matching entry, lowest index wins |
| hit_func | output | 2 | Function bits of the matching address |

## Verification
A corrupted table entry shows at the ports on the first address codeword that carries the affected identity. That codeword either misses or reports the wrong index, and the effect appears one cycle after the codeword leaves the input stage. A wrong held class, frame or function value shows up in the next result cycle as a wrong `out_class`, a false hit or a wrong `hit_func`. A stuck or doubled stage-valid shows up at once as a missing or repeated `out_valid` pulse. The sweep is built so that every table entry and every frame slot is reached within a few hundred codewords.

// File: rtl/pam_pkg.sv
package pam_pkg;
  localparam int CW_W    = 32;
  localparam int ID_W    = 21;
  localparam int FRAME_W = 3;
  localparam int UP_W    = ID_W - FRAME_W;
  localparam int UP_HI   = CW_W - 2;
  localparam int UP_LO   = UP_HI - UP_W + 1;
  localparam int FN_HI   = UP_LO - 1;
  localparam int FN_LO   = UP_LO - 2;
  localparam logic [CW_W-1:0] IDLE_WORD = 32'h7A89C197;

  typedef enum logic [1:0] {
    CLS_IDLE = 2'd0,
    CLS_ADDR = 2'd1,
    CLS_MSG  = 2'd2
  } cw_class_e;
endpackage

// File: rtl/pam_classify.sv
module pam_classify
  import pam_pkg::*;
#(
  parameter logic [CW_W-1:0] IDLE_PATTERN = IDLE_WORD
) (
  input  logic [CW_W-1:0] word,
  output cw_class_e       cls
);
  always_comb begin
    if (word == IDLE_PATTERN)  cls = CLS_IDLE;
    else if (word[CW_W-1])     cls = CLS_MSG;
    else                       cls = CLS_ADDR;
  end
endmodule

// File: rtl/pam_id_table.sv
module pam_id_table
  import pam_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int IDX_W     = 2
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            wr_ok,
  input  logic [IDX_W-1:0]                wr_idx,
  input  logic [ID_W-1:0]                 wr_id,
  input  logic                            wr_on,
  output logic [N_ENTRIES-1:0][ID_W-1:0]  ids,
  output logic [N_ENTRIES-1:0]            ens
);
  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk) begin
      if (rst) begin
        ids[g] <= '0;
        ens[g] <= 1'b0;
      end else if (wr_ok && wr_idx == IDX_W'(g)) begin
        ids[g] <= wr_id;
        ens[g] <= wr_on;
      end
    end
  end
endmodule

// File: rtl/pam_match.sv
module pam_match
  import pam_pkg::*;
#(
  parameter int N_ENTRIES = 4,
  parameter int IDX_W     = 2
) (
  input  logic [UP_W-1:0]                 upper,
  input  logic [FRAME_W-1:0]              frame,
  input  logic [N_ENTRIES-1:0][ID_W-1:0]  ids,
  input  logic [N_ENTRIES-1:0]            ens,
  output logic                            any_hit,
  output logic [IDX_W-1:0]                first_idx
);
  logic [N_ENTRIES-1:0] eq;

  for (genvar g = 0; g < N_ENTRIES; g++) begin : g_cmp
    assign eq[g] = ens[g]
                && (ids[g][ID_W-1:FRAME_W] == upper)
                && (ids[g][FRAME_W-1:0] == frame);
  end

  always_comb begin
    any_hit   = 1'b0;
    first_idx = '0;
    for (int i = N_ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) begin
        any_hit   = 1'b1;
        first_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/paging_addr_matcher.sv
module paging_addr_matcher
  import pam_pkg::*;
#(
  parameter int               N_ENTRIES    = 4,
  parameter logic [CW_W-1:0]  IDLE_PATTERN = IDLE_WORD,
  localparam int              IDX_W        = (N_ENTRIES > 1) ? $clog2(N_ENTRIES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic [CW_W-1:0]    in_word,
  input  logic [FRAME_W-1:0] in_frame,
  input  logic               wr_en,
  input  logic [IDX_W-1:0]   wr_idx,
  input  logic [ID_W-1:0]    wr_id,
  input  logic               wr_on,
  output logic               out_valid,
  output logic [1:0]         out_class,
  output logic               hit,
  output logic [IDX_W-1:0]   hit_idx,
  output logic [1:0]         hit_func
);
  cw_class_e                      in_cls;
  logic                           fire;
  logic                           s_valid;
  cw_class_e                      s_cls;
  logic [UP_W-1:0]                s_upper;
  logic [1:0]                     s_func;
  logic [FRAME_W-1:0]             s_frame;
  logic [N_ENTRIES-1:0][ID_W-1:0] tbl_ids;
  logic [N_ENTRIES-1:0]           tbl_ens;
  logic                           m_hit;
  logic [IDX_W-1:0]               m_idx;
  logic                           wr_ok;

  assign in_ready = !wr_en;
  assign fire     = in_valid && in_ready;
  assign wr_ok    = wr_en && !s_valid;

  pam_classify #(.IDLE_PATTERN(IDLE_PATTERN)) u_cls (
    .word (in_word),
    .cls  (in_cls)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      s_valid <= 1'b0;
      s_cls   <= CLS_IDLE;
      s_upper <= '0;
      s_func  <= '0;
      s_frame <= '0;
    end else begin
      s_valid <= fire;
      if (fire) begin
        s_cls   <= in_cls;
        s_upper <= in_word[UP_HI:UP_LO];
        s_func  <= in_word[FN_HI:FN_LO];
        s_frame <= in_frame;
      end
    end
  end

  pam_id_table #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_tbl (
    .clk    (clk),
    .rst    (rst),
    .wr_ok  (wr_ok),
    .wr_idx (wr_idx),
    .wr_id  (wr_id),
    .wr_on  (wr_on),
    .ids    (tbl_ids),
    .ens    (tbl_ens)
  );

  pam_match #(.N_ENTRIES(N_ENTRIES), .IDX_W(IDX_W)) u_match (
    .upper     (s_upper),
    .frame     (s_frame),
    .ids       (tbl_ids),
    .ens       (tbl_ens),
    .any_hit   (m_hit),
    .first_idx (m_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_class <= 2'd0;
      hit       <= 1'b0;
      hit_idx   <= '0;
      hit_func  <= '0;
    end else begin
      out_valid <= s_valid;
      out_class <= s_cls;
      hit       <= s_valid && (s_cls == CLS_ADDR) && m_hit;
      hit_idx   <= m_idx;
      hit_func  <= s_func;
    end
  end
endmodule

// File: rtl/pam_checker.sv
module pam_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_ready,
  input logic       wr_en,
  input logic       out_valid,
  input logic [1:0] out_class,
  input logic       hit
);
  // R9
  result_has_source_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready, 2));

  // R9
  hit_needs_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> out_valid);

  // R4
  hit_only_address_chk: assert property (@(posedge clk) disable iff (rst)
    hit |-> (out_class == 2'd1));

  // R10
  write_blocks_input_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> !in_ready);

  // R2
  class_code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_class != 2'd3));
endmodule

bind paging_addr_matcher pam_checker u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .wr_en     (wr_en),
  .out_valid (out_valid),
  .out_class (out_class),
  .hit       (hit)
);

// File: tb/sim_paging_addr_matcher.sv
module sim_paging_addr_matcher;
  localparam logic [31:0] IDLE = 32'h7A89C197;

  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_ready;
  logic [31:0] in_word;
  logic [2:0]  in_frame;
  logic        wr_en;
  logic [1:0]  wr_idx;
  logic [20:0] wr_id;
  logic        wr_on;
  logic        out_valid;
  logic [1:0]  out_class;
  logic        hit;
  logic [1:0]  hit_idx;
  logic [1:0]  hit_func;

  int checks = 0;
  int fails  = 0;

  logic [20:0] m_id [4];
  logic        m_en [4];

  always #4 clk = ~clk;

  paging_addr_matcher u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_frame(in_frame), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_id(wr_id), .wr_on(wr_on), .out_valid(out_valid), .out_class(out_class),
    .hit(hit), .hit_idx(hit_idx), .hit_func(hit_func)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mkword(input logic msb, input logic [17:0] up,
                                         input logic [1:0] fn);
    return {msb, up, fn, 11'h5A5};
  endfunction

  task automatic expect_of(input logic [31:0] w, input logic [2:0] f,
                           output logic [1:0] cls, output logic eh, output logic [1:0] ei);
    eh = 1'b0;
    ei = 2'd0;
    if (w == IDLE) cls = 2'd0;
    else if (w[31]) cls = 2'd2;
    else begin
      cls = 2'd1;
      for (int i = 3; i >= 0; i--)
        if (m_en[i] && m_id[i] == {w[30:13], f}) begin
          eh = 1'b1;
          ei = 2'(i);
        end
    end
  endtask

  task automatic check_result(input string req, input logic [31:0] w, input logic [2:0] f);
    logic [1:0] cls;
    logic       eh;
    logic [1:0] ei;
    expect_of(w, f, cls, eh, ei);
    check({req, " R9 strobe"}, 32'(out_valid), 32'd1);
    check({req, " class R2 R3 R4"}, 32'(out_class), 32'(cls));
    check({req, " hit R4 R5 R8"}, 32'(hit), 32'(eh));
    if (eh) begin
      check({req, " index R7"}, 32'(hit_idx), 32'(ei));
      check({req, " func R6"}, 32'(hit_func), 32'(w[12:11]));
    end
  endtask

  task automatic send(input string req, input logic [31:0] w, input logic [2:0] f);
    @(negedge clk);
    in_valid = 1'b1; in_word = w; in_frame = f;
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    check_result(req, w, f);
    @(negedge clk);
    check({req, " single pulse R9"}, 32'(out_valid), 32'd0);
  endtask

  task automatic write(input logic [1:0] idx, input logic [20:0] id, input logic on);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_id = id; wr_on = on;
    #1;
    check("write stalls input R10", 32'(in_ready), 32'd0);
    @(negedge clk);
    wr_en = 1'b0;
    m_id[idx] = id;
    m_en[idx] = on;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [20:0] ids [4];
    logic [17:0] ups [3];
    logic [31:0] seq [3];
    logic [2:0]  sf  [3];
    rst = 1'b1; in_valid = 1'b0; in_word = '0; in_frame = '0;
    wr_en = 1'b0; wr_idx = '0; wr_id = '0; wr_on = 1'b0;
    for (int i = 0; i < 4; i++) begin m_id[i] = '0; m_en[i] = 1'b0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("reset strobe R1", 32'(out_valid), 32'd0);
    check("reset hit R1", 32'(hit), 32'd0);
    // R1: empty table never hits, including identity zero
    send("R1 empty", mkword(1'b0, 18'h0, 2'd0), 3'd0);

    ids[0] = 21'h1A2B3C; ids[1] = 21'h0F0F0F;
    ids[2] = 21'h1A2B39; ids[3] = 21'h0F0F0F;
    for (int i = 0; i < 4; i++) write(2'(i), ids[i], 1'b1);

    // R4 R5 R6 R7: sweep frame, upper bits, function bits and top bit
    ups[0] = ids[0][20:3]; ups[1] = ids[1][20:3]; ups[2] = 18'h2AAAA;
    for (int f = 0; f < 8; f++)
      for (int u = 0; u < 3; u++)
        for (int fn = 0; fn < 4; fn++)
          for (int m = 0; m < 2; m++)
            send("R4 sweep", mkword(m[0], ups[u], fn[1:0]), f[2:0]);

    // R2: idle word never hits even with a matching entry
    write(2'd2, {IDLE[30:13], 3'd5}, 1'b1);
    send("R2 idle", IDLE, 3'd5);
    send("R4 near idle", IDLE ^ 32'h1, 3'd5);

    // R8: disabled entry never hits
    write(2'd0, ids[0], 1'b0);
    send("R8 disabled", mkword(1'b0, ids[0][20:3], 2'd3), ids[0][2:0]);

    // R11: write while a codeword is held is dropped
    @(negedge clk);
    in_valid = 1'b1; in_word = mkword(1'b1, 18'h0, 2'd0); in_frame = 3'd0;
    @(negedge clk);
    in_valid = 1'b0;
    wr_en = 1'b1; wr_idx = 2'd1; wr_id = 21'h155555; wr_on = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
    check("R11 held word result R9", 32'(out_valid), 32'd1);
    send("R11 dropped write", mkword(1'b0, 18'h2AAAA, 2'd1), 3'd5);
    check("R11 old entry kept", 32'(m_id[1]), 32'(ids[1]));
    send("R11 old entry still hits", mkword(1'b0, ids[1][20:3], 2'd2), ids[1][2:0]);

    // R10: codeword offered during a write is not taken; write still lands
    @(negedge clk);
    in_valid = 1'b1; in_word = mkword(1'b0, 18'h0, 2'd0); in_frame = 3'd0;
    wr_en = 1'b1; wr_idx = 2'd3; wr_id = 21'h000006; wr_on = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; wr_en = 1'b0;
    m_id[3] = 21'h000006; m_en[3] = 1'b1;
    @(negedge clk);
    check("R10 no result from stalled word", 32'(out_valid), 32'd0);
    @(negedge clk);
    check("R10 no late result", 32'(out_valid), 32'd0);
    send("R10 write landed", mkword(1'b0, 18'h0, 2'd2), 3'd6);

    // R9: back-to-back stream
    seq[0] = mkword(1'b0, ids[1][20:3], 2'd1); sf[0] = ids[1][2:0];
    seq[1] = IDLE;                             sf[1] = 3'd2;
    seq[2] = mkword(1'b1, 18'h3, 2'd0);        sf[2] = 3'd4;
    @(negedge clk);
    for (int k = 0; k < 5; k++) begin
      if (k < 3) begin in_valid = 1'b1; in_word = seq[k]; in_frame = sf[k]; end
      else in_valid = 1'b0;
      if (k >= 2) check_result("R9 stream", seq[k-2], sf[k-2]);
      @(negedge clk);
    end
    check("R9 stream ends", 32'(out_valid), 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule